// File: doc/BRIEF.md
# Serial Receiver with Break Detection

This block receives asynchronous serial frames on a single line and keeps a status word for them. The line is brought into the clock domain by a two-stage synchronizer. Bits are sampled from an oversampling enable that pulses sixteen times per bit period. The frame format can be configured: five to eight data bits, an optional extra ninth data bit, and optional even or odd parity. Each completed word goes into a receive data register. A data-ready flag stays set until that register is read.

The same line is also timed for break conditions. Low time is counted in whole bit periods. It is compared against two thresholds that follow from the frame length M (start bit, data bits, ninth bit, parity bit, stop bit). Holding the line low for more than M bit periods raises a short-break flag. Holding it low for more than 2M + 3 bit periods raises a long-break flag.

If the line drops while a frame is being received, that frame is completed first. Its stop bit then samples low and it reports a framing error. Break timing begins only after that frame has completed.

Framing, parity, overrun, ninth-bit and both break flags are sticky. Each is cleared by its own bit of a clear strobe.

Top module: `uart_rx_brk`

## Requirements
- R1: A frame is a low start bit, `data_bits_i` data bits sent least significant bit first, an optional ninth bit, an optional parity bit and a stop bit. On the stop bit the word loads into `data_o`, zero-extended above `data_bits_i`, and `ready_o` goes to 1.
- R2: A low pulse shorter than half a bit period does not start a frame. The receiver stays idle and produces no word.
- R3: When `par_en_i` is 1, the parity bit follows the data. `par_odd_i` = 0 selects even parity and `par_odd_i` = 1 selects odd parity, counted over all data bits including the ninth bit. A mismatch sets `perr_o`.
- R4: When `nine_bit_i` is 1, a ninth data bit follows the data bits. When it is received as 1, `ninth_o` is set, and it stays set across later words until it is cleared.
- R5: A stop bit sampled low sets `ferr_o`. A new start bit is accepted only after the line has returned high.
- R6: `ready_o` clears on the cycle after `rd_i` is asserted, unless a word completes in that same cycle.
- R7: When a word completes while `ready_o` is 1, `ovr_o` is set and `data_o` keeps the earlier word.
- R8: While the receiver is idle, a line held low for more than M bit periods sets `brk_short_o`. M = 2 + `data_bits_i` + `nine_bit_i` + `par_en_i`. Holding it low for exactly M bit periods does not set the flag. A break produces at most one word.
- R9: A line held low for more than 2M + 3 bit periods sets `brk_long_o`. Holding it for 2M + 2 bit periods does not.
- R10: If the line falls during a frame, break timing starts only when that frame completes. Low time before the stop bit sample does not count toward either threshold.
- R11: The ferr, perr, ovr, brk_short, brk_long and ninth flags are sticky. They are cleared by `clr_i` bits 0, 1, 2, 3, 4 and 5 respectively. A set in the same cycle takes priority over a clear.
- R12: After reset all flags are 0 and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | Oversampling enable, 16 pulses per bit period |
| data_bits_i | input | 4 | Number of data bits, 5 to 8 |
| nine_bit_i | input | 1 | Adds a ninth data bit |
| par_en_i | input | 1 | Enables the parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_i | input | 1 | Read strobe for the receive data register |
| clr_i | input | 6 | Per-flag clear strobes |
| data_o | output | 8 | Receive data register |
| ninth_o | output | 1 | Sticky ninth received bit |
| ready_o | output | 1 | Data ready |
| ferr_o | output | 1 | Sticky framing error |
| perr_o | output | 1 | Sticky parity error |
| ovr_o | output | 1 | Sticky overrun |
| brk_short_o | output | 1 | Sticky short-break flag |
| brk_long_o | output | 1 | Sticky long-break flag |

## Verification
A wrong bit counter or sample phase shows up at the next stop bit, one frame time later. It appears as a shifted or wrong word, or as a spurious framing or parity error, at the moment `ready_o` rises. Faults in the break timer show up only after about M or 2M + 3 bit periods of low line. For that reason the bench holds the line just below and just above each threshold. It also starts a break inside a frame, where a timer that counted from the falling edge would set `brk_short_o` too early. Errors in the status register show up on the cycle after a read or clear strobe.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // bit positions in the clear strobe vector
  localparam int unsigned CLR_FERR  = 0;
  localparam int unsigned CLR_PERR  = 1;
  localparam int unsigned CLR_OVR   = 2;
  localparam int unsigned CLR_SBRK  = 3;
  localparam int unsigned CLR_LBRK  = 4;
  localparam int unsigned CLR_NINTH = 5;
  localparam int unsigned CLR_W     = 6;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_MAX = 8,
  parameter int unsigned OS       = 16,
  parameter int unsigned DBW      = $clog2(DATA_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic                tick_i,
  input  logic [DBW-1:0]      data_bits_i,
  input  logic                nine_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_MAX-1:0] word_o,
  output logic                ninth_o,
  output logic                ferr_o,
  output logic                perr_o
);

  localparam int unsigned OSW = $clog2(OS);
  localparam int unsigned IW  = $clog2(DATA_MAX + 2);
  localparam logic [OSW-1:0] HALF_M1 = OSW'(OS / 2 - 1);
  localparam logic [OSW-1:0] LAST    = OSW'(OS - 1);

  rx_state_e           state_q;
  logic [OSW-1:0]      os_q;
  logic [IW-1:0]       idx_q;
  logic [DATA_MAX-1:0] sh_q;
  logic                nb_q, par_q, perr_q, ferr_q, done_q, armed_q;
  logic [IW-1:0]       nbits;
  logic                mid;

  assign nbits = IW'(data_bits_i) + IW'(nine_i);
  assign mid   = tick_i && (os_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      nb_q    <= 1'b0;
      par_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          // a start needs a high-to-low transition
          if (rx_i) armed_q <= 1'b1;
          else if (tick_i && armed_q) begin
            state_q <= ST_START;
            os_q    <= '0;
            armed_q <= 1'b0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (os_q == HALF_M1) begin
              os_q <= '0;
              if (!rx_i) begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                sh_q    <= '0;
                nb_q    <= 1'b0;
                par_q   <= 1'b0;
                perr_q  <= 1'b0;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              os_q <= os_q + OSW'(1);
            end
          end
        end
        ST_DATA: begin
          if (mid) begin
            os_q <= '0;
            for (int i = 0; i < DATA_MAX; i++) begin
              if (idx_q == IW'(i) && idx_q < IW'(data_bits_i)) sh_q[i] <= rx_i;
            end
            if (idx_q == IW'(data_bits_i)) nb_q <= rx_i;
            par_q <= par_q ^ rx_i;
            idx_q <= idx_q + IW'(1);
            if (idx_q == nbits - IW'(1)) state_q <= par_en_i ? ST_PAR : ST_STOP;
          end else if (tick_i) begin
            os_q <= os_q + OSW'(1);
          end
        end
        ST_PAR: begin
          if (mid) begin
            os_q    <= '0;
            perr_q  <= ((par_q ^ rx_i) != par_odd_i);
            state_q <= ST_STOP;
          end else if (tick_i) begin
            os_q <= os_q + OSW'(1);
          end
        end
        ST_STOP: begin
          if (mid) begin
            os_q    <= '0;
            done_q  <= 1'b1;
            ferr_q  <= !rx_i;
            armed_q <= rx_i;
            state_q <= ST_IDLE;
          end else if (tick_i) begin
            os_q <= os_q + OSW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign word_o  = sh_q;
  assign ninth_o = nb_q;
  assign ferr_o  = ferr_q;
  assign perr_o  = perr_q;

  assert_glitch_rejected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && os_q == HALF_M1 && rx_i) |=> (state_q == ST_IDLE && !done_q));

  assert_done_after_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE && $past(state_q) == ST_STOP));

endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break #(
  parameter int unsigned OS = 16,
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          busy_i,
  input  logic [CW-1:0] m_len_i,
  output logic          short_o,
  output logic          long_o
);

  localparam int unsigned OSW = $clog2(OS);
  localparam logic [OSW-1:0] LAST = OSW'(OS - 1);

  logic           run_q, short_q, long_q;
  logic [OSW-1:0] sub_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  short_th, long_th, cnt_nx;
  logic           bit_end;

  assign short_th = m_len_i + CW'(1);
  assign long_th  = {m_len_i[CW-2:0], 1'b0} + CW'(4);
  assign cnt_nx   = cnt_q + CW'(1);
  assign bit_end  = tick_i && (sub_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      sub_q   <= '0;
      cnt_q   <= '0;
      short_q <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      short_q <= 1'b0;
      long_q  <= 1'b0;
      if (rx_i) begin
        run_q <= 1'b0;
        sub_q <= '0;
        cnt_q <= '0;
      end else if (run_q || !busy_i) begin
        // timing only opens while no frame is in progress
        run_q <= 1'b1;
        if (tick_i) sub_q <= (sub_q == LAST) ? '0 : sub_q + OSW'(1);
        if (bit_end && cnt_q != long_th) begin
          cnt_q   <= cnt_nx;
          short_q <= (cnt_nx == short_th);
          long_q  <= (cnt_nx == long_th);
        end
      end
    end
  end

  assign short_o = short_q;
  assign long_o  = long_q;

  assert_timing_deferred_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !run_q) |=> !run_q);

  assert_long_beyond_short_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_q |-> (cnt_q > short_th));

  assert_low_for_short_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_q |-> ($past(!rx_i) && run_q));

endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_MAX = 8,
  parameter int unsigned OS       = 16,
  parameter int unsigned DBW      = $clog2(DATA_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_i,
  input  logic                tick_i,
  input  logic [DBW-1:0]      data_bits_i,
  input  logic                nine_bit_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                rd_i,
  input  logic [CLR_W-1:0]    clr_i,
  output logic [DATA_MAX-1:0] data_o,
  output logic                ninth_o,
  output logic                ready_o,
  output logic                ferr_o,
  output logic                perr_o,
  output logic                ovr_o,
  output logic                brk_short_o,
  output logic                brk_long_o
);

  localparam int unsigned M_MAX = DATA_MAX + 4;
  localparam int unsigned CW    = $clog2(2 * M_MAX + 5);

  logic                rx_s;
  logic                frm_busy, frm_done, frm_ninth, frm_ferr, frm_perr;
  logic [DATA_MAX-1:0] frm_word;
  logic                brk_s, brk_l;
  logic [CW-1:0]       m_len;

  logic [DATA_MAX-1:0] data_q;
  logic                ready_q, ninth_q, ferr_q, perr_q, ovr_q, sbrk_q, lbrk_q;

  assign m_len = CW'(2) + CW'(data_bits_i) + CW'(nine_bit_i) + CW'(par_en_i);

  uart_rx_sync #(.STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (rx_s)
  );

  uart_rx_frame #(.DATA_MAX(DATA_MAX), .OS(OS), .DBW(DBW)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_i        (rx_s),
    .tick_i      (tick_i),
    .data_bits_i (data_bits_i),
    .nine_i      (nine_bit_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .busy_o      (frm_busy),
    .done_o      (frm_done),
    .word_o      (frm_word),
    .ninth_o     (frm_ninth),
    .ferr_o      (frm_ferr),
    .perr_o      (frm_perr)
  );

  uart_rx_break #(.OS(OS), .CW(CW)) u_break (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_s),
    .tick_i  (tick_i),
    .busy_i  (frm_busy),
    .m_len_i (m_len),
    .short_o (brk_s),
    .long_o  (brk_l)
  );

  // clears first, sets after: a set in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      ninth_q <= 1'b0;
      ferr_q  <= 1'b0;
      perr_q  <= 1'b0;
      ovr_q   <= 1'b0;
      sbrk_q  <= 1'b0;
      lbrk_q  <= 1'b0;
    end else begin
      if (rd_i)             ready_q <= 1'b0;
      if (clr_i[CLR_FERR])  ferr_q  <= 1'b0;
      if (clr_i[CLR_PERR])  perr_q  <= 1'b0;
      if (clr_i[CLR_OVR])   ovr_q   <= 1'b0;
      if (clr_i[CLR_SBRK])  sbrk_q  <= 1'b0;
      if (clr_i[CLR_LBRK])  lbrk_q  <= 1'b0;
      if (clr_i[CLR_NINTH]) ninth_q <= 1'b0;
      if (brk_s) sbrk_q <= 1'b1;
      if (brk_l) lbrk_q <= 1'b1;
      if (frm_done) begin
        if (frm_ferr) ferr_q <= 1'b1;
        if (frm_perr) perr_q <= 1'b1;
        if (ready_q) begin
          ovr_q <= 1'b1;
        end else begin
          data_q  <= frm_word;
          ready_q <= 1'b1;
          if (nine_bit_i && frm_ninth) ninth_q <= 1'b1;
        end
      end
    end
  end

  assign data_o      = data_q;
  assign ready_o     = ready_q;
  assign ninth_o     = ninth_q;
  assign ferr_o      = ferr_q;
  assign perr_o      = perr_q;
  assign ovr_o       = ovr_q;
  assign brk_short_o = sbrk_q;
  assign brk_long_o  = lbrk_q;

  assert_word_sets_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && !ready_q) |=> ready_q);

  assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !frm_done) |=> !ready_q);

  assert_overrun_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_done && ready_q) |=> (ovr_q && $stable(data_q)));

  assert_short_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[CLR_SBRK] && !brk_s) |=> !sbrk_q);

endmodule

// File: tb/uart_rx_brk_test.sv
module uart_rx_brk_test;
  import uart_rx_pkg::*;

  typedef struct {
    logic [7:0] d;
    logic       n9;
    logic       fe;
    logic       pe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic [3:0] dbits = 4'd8;
  logic       nine = 1'b0, pen = 1'b0, podd = 1'b0;
  logic       mon_rd = 1'b0, man_rd = 1'b0;
  logic [5:0] mon_clr = '0, man_clr = '0;
  logic       mon_en = 1'b0;

  logic [7:0] data_o;
  logic       ninth_o, ready_o, ferr_o, perr_o, ovr_o, bs_o, bl_o;

  int   vecs = 0;
  int   errs = 0;
  exp_t q[$];

  always #10 clk = ~clk;

  always @(posedge clk) tick <= rst_n ? ~tick : 1'b0;

  uart_rx_brk uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rx_i        (rx),
    .tick_i      (tick),
    .data_bits_i (dbits),
    .nine_bit_i  (nine),
    .par_en_i    (pen),
    .par_odd_i   (podd),
    .rd_i        (mon_rd | man_rd),
    .clr_i       (mon_clr | man_clr),
    .data_o      (data_o),
    .ninth_o     (ninth_o),
    .ready_o     (ready_o),
    .ferr_o      (ferr_o),
    .perr_o      (perr_o),
    .ovr_o       (ovr_o),
    .brk_short_o (bs_o),
    .brk_long_o  (bl_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one bit period = 16 ticks = 32 clocks
  task automatic line(input logic v, input int n);
    rx = v;
    repeat (n * 32) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic n9, input logic badp,
                            input logic stopv, input logic push);
    logic [7:0] m;
    logic p;
    exp_t e;
    m = d & 8'((9'd1 << dbits) - 9'd1);
    e.d = m; e.n9 = nine & n9; e.fe = !stopv; e.pe = badp;
    if (push) q.push_back(e);
    line(1'b0, 1);
    for (int i = 0; i < int'(dbits); i++) line(d[i], 1);
    if (nine) line(n9, 1);
    if (pen) begin
      p = (^m) ^ (nine & n9);
      if (podd) p = ~p;
      if (badp) p = ~p;
      line(p, 1);
    end
    line(stopv, 1);
    line(1'b1, 2);
  endtask

  task automatic push_zero_word();
    exp_t e;
    e.d = 8'h00; e.n9 = 1'b0; e.fe = 1'b1; e.pe = 1'b0;
    q.push_back(e);
  endtask

  // start bit, three high data bits, then low for n bit periods
  task automatic mid_break(input int n);
    exp_t e;
    e.d = 8'h07; e.n9 = 1'b0; e.fe = 1'b1; e.pe = 1'b0;
    q.push_back(e);
    line(1'b0, 1);
    line(1'b1, 3);
    line(1'b0, n);
    line(1'b1, 3);
  endtask

  task automatic do_read();
    man_rd = 1'b1;
    @(negedge clk);
    man_rd = 1'b0;
  endtask

  task automatic do_clr(input int idx);
    man_clr[idx] = 1'b1;
    @(negedge clk);
    man_clr = '0;
  endtask

  // monitor: pop expected word on each ready, then read and clear
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && ready_o) begin
        exp_t e;
        if (q.size() == 0) begin
          vecs++;
          errs++;
          $display("FAIL R1 unexpected word act=%h exp=none", data_o);
        end else begin
          e = q.pop_front();
          chk("R1 R3 R4 R5 word/ninth/ferr/perr", {21'd0, data_o, ninth_o, ferr_o, perr_o},
              {21'd0, e.d, e.n9, e.fe, e.pe});
        end
        mon_rd  = 1'b1;
        mon_clr = '1;
        @(negedge clk);
        mon_rd  = 1'b0;
        mon_clr = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    vecs++;
    errs++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R12 reset state", {16'd0, ready_o, ninth_o, ferr_o, perr_o, ovr_o, bs_o, bl_o, 1'b0, data_o},
        32'd0);
    rst_n = 1'b1;
    line(1'b1, 2);
    mon_en = 1'b1;

    // R1: 8N1 patterns
    send_frame(8'hA5, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'h3C, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'hFF, 1'b0, 1'b0, 1'b1, 1'b1);
    // R1: five data bits, zero extension
    dbits = 4'd5;
    send_frame(8'hB5, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'h0A, 1'b0, 1'b0, 1'b1, 1'b1);
    dbits = 4'd8;

    // R2: short glitch
    rx = 1'b0;
    repeat (8) @(negedge clk);
    line(1'b1, 3);
    chk("R2 glitch gives no word", {31'd0, ready_o}, 32'd0);
    send_frame(8'h66, 1'b0, 1'b0, 1'b1, 1'b1);

    // R3: parity, 7 data bits
    dbits = 4'd7; pen = 1'b1; podd = 1'b0;
    send_frame(8'h55, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'h2A, 1'b0, 1'b1, 1'b1, 1'b1);
    podd = 1'b1;
    send_frame(8'h13, 1'b0, 1'b0, 1'b1, 1'b1);
    send_frame(8'h40, 1'b0, 1'b1, 1'b1, 1'b1);
    pen = 1'b0; podd = 1'b0; dbits = 4'd8;

    // R5: framing error
    send_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b1);
    send_frame(8'h42, 1'b0, 1'b0, 1'b1, 1'b1);

    // R4: ninth bit
    nine = 1'b1;
    send_frame(8'h81, 1'b1, 1'b0, 1'b1, 1'b1);
    send_frame(8'h7E, 1'b0, 1'b0, 1'b1, 1'b1);
    mon_en = 1'b0;
    send_frame(8'hC3, 1'b1, 1'b0, 1'b1, 1'b0);
    do_read();
    send_frame(8'h11, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4 ninth stays set", {31'd0, ninth_o}, 32'd1);
    chk("R4 second word loaded", {24'd0, data_o}, 32'h11);
    do_clr(CLR_NINTH);
    chk("R11 ninth cleared", {31'd0, ninth_o}, 32'd0);
    do_read();
    nine = 1'b0;

    // R7: overrun
    send_frame(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0);
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 old word kept", {24'd0, data_o}, 32'h5A);
    chk("R7 overrun flag", {30'd0, ovr_o, ready_o}, 32'd3);
    do_read();
    chk("R6 read clears ready", {31'd0, ready_o}, 32'd0);
    chk("R11 overrun sticky after read", {31'd0, ovr_o}, 32'd1);
    do_clr(CLR_OVR);
    chk("R11 overrun cleared", {31'd0, ovr_o}, 32'd0);
    mon_en = 1'b1;

    // R8/R9: breaks from idle, 8N1 so M = 10
    push_zero_word();
    line(1'b0, 10);
    line(1'b1, 3);
    chk("R8 low M bits no short", {30'd0, bs_o, bl_o}, 32'd0);
    push_zero_word();
    line(1'b0, 12);
    line(1'b1, 3);
    chk("R8 short set, long clear", {30'd0, bs_o, bl_o}, 32'd2);
    chk("R8 single word per break", {31'd0, ready_o} | 32'(q.size()), 32'd0);
    do_clr(CLR_SBRK);
    chk("R11 short cleared", {31'd0, bs_o}, 32'd0);
    push_zero_word();
    line(1'b0, 22);
    line(1'b1, 3);
    chk("R9 below long threshold", {30'd0, bs_o, bl_o}, 32'd2);
    do_clr(CLR_SBRK);
    push_zero_word();
    line(1'b0, 26);
    line(1'b1, 3);
    chk("R9 long break", {30'd0, bs_o, bl_o}, 32'd3);
    do_clr(CLR_LBRK);
    chk("R11 long cleared", {31'd0, bl_o}, 32'd0);
    do_clr(CLR_SBRK);

    // R10: break starting inside a frame
    mid_break(14);
    chk("R10 timing deferred, no short", {30'd0, bs_o, bl_o}, 32'd0);
    mid_break(18);
    chk("R10 short after frame end", {30'd0, bs_o, bl_o}, 32'd2);

    chk("R1 scoreboard drained", 32'(q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule